// File: doc/BRIEF.md
# Codec Command and DMA Register Bank

This block is the software-visible register file of an audio codec controller. It sits on a 32-bit word-addressed slave bus. It holds four codec command words: control, address, outgoing data and incoming data. For each of a playback DMA channel and a capture DMA channel it also holds a control word, a buffer address and a remaining byte count. Every stored word is driven straight out of the block, so the codec link logic and the two DMA engines can see the values that software programmed.

Software starts a codec transaction by writing the codec control word with its request bit set. That bit is never stored. The same write also holds a direction bit. That bit decides whether the request interrupt or the reply interrupt fires, as a pulse one clock wide. While the DMA engines move data, they report progress through a dedicated write-back port that updates the address and remaining registers of their channel. When the engine and software write the same register in the same cycle, the engine's value is kept.

Top module: `codec_regbank`

## Requirements
- R1: After reset, every register reads 0, every exported value and enable is 0, and both interrupt outputs are low.
- R2: A full-word aligned write stores the data at register index addr[5:2], and a read returns it in the same cycle. The index map is: 0 codec control, 1 codec address, 2 codec data-out, 3 codec data-in, 4 playback control, 5 playback address, 6 playback remaining, 8 capture control, 9 capture address, 10 capture remaining. The exported outputs carry the same stored values.
- R3: An access whose byte enables are not all 1 (4'hF) has no effect. A read of that kind returns 0.
- R4: Bit 0 of codec control (the request bit) is never stored. The register reads back as the written value with bit 0 at 0.
- R5: A write to codec control with bit 0 = 1 and bit 1 = 1 raises irq_req for exactly the one cycle after the write edge.
- R6: A write to codec control with bit 0 = 1 and bit 1 = 0 raises irq_reply for exactly the one cycle after the write edge. The two interrupts are never high together.
- R7: A write to codec control with bit 0 = 0 raises neither interrupt.
- R8: play_en and cap_en equal bit 0 of the playback control register and the capture control register.
- R9: Index 7, indices 11 to 15 and misaligned addresses (addr[1:0] not 0) are ignored on write. A read of them returns 0.
- R10: A write-back strobe from a DMA engine loads its value into that channel's address or remaining register. It wins over a bus write to the same register in the same cycle, and leaves bus writes to other registers unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | DATA_W/8 | Byte enables; only all ones is accepted |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rd is high |
| play_wb_addr_en | input | 1 | Playback address write-back strobe |
| play_wb_addr | input | DATA_W | Playback address write-back value |
| play_wb_rem_en | input | 1 | Playback remaining write-back strobe |
| play_wb_rem | input | DATA_W | Playback remaining write-back value |
| cap_wb_addr_en | input | 1 | Capture address write-back strobe |
| cap_wb_addr | input | DATA_W | Capture address write-back value |
| cap_wb_rem_en | input | 1 | Capture remaining write-back strobe |
| cap_wb_rem | input | DATA_W | Capture remaining write-back value |
| codec_ctrl | output | DATA_W | Stored codec control word |
| codec_addr | output | DATA_W | Codec register address |
| codec_dout | output | DATA_W | Codec outgoing data |
| codec_din | output | DATA_W | Codec incoming data |
| play_en | output | 1 | Playback channel enable |
| play_addr | output | DATA_W | Playback buffer address |
| play_rem | output | DATA_W | Playback remaining count |
| cap_en | output | 1 | Capture channel enable |
| cap_addr | output | DATA_W | Capture buffer address |
| cap_rem | output | DATA_W | Capture remaining count |
| irq_req | output | 1 | Request interrupt pulse |
| irq_reply | output | 1 | Reply interrupt pulse |

## Verification
The assertions check on every cycle the interrupt behaviour. A request write with either direction gives the matching one-cycle pulse, a write without the request bit gives none, and the two lines never rise together. They also check that codec control never reads back with bit 0 set, that reserved reads return 0, that the enables agree with the control words, and that a write-back value always lands. Only the bench scenarios can show the full register map: no aliasing between indices, partial and misaligned accesses that leave the contents unchanged, bus writes next to write-backs in the same cycle, and a reset in mid-run clearing everything.

// File: rtl/codec_regbank.sv
module codec_regbank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              play_wb_addr_en,
  input  logic [DATA_W-1:0] play_wb_addr,
  input  logic              play_wb_rem_en,
  input  logic [DATA_W-1:0] play_wb_rem,
  input  logic              cap_wb_addr_en,
  input  logic [DATA_W-1:0] cap_wb_addr,
  input  logic              cap_wb_rem_en,
  input  logic [DATA_W-1:0] cap_wb_rem,
  output logic [DATA_W-1:0] codec_ctrl,
  output logic [DATA_W-1:0] codec_addr,
  output logic [DATA_W-1:0] codec_dout,
  output logic [DATA_W-1:0] codec_din,
  output logic              play_en,
  output logic [DATA_W-1:0] play_addr,
  output logic [DATA_W-1:0] play_rem,
  output logic              cap_en,
  output logic [DATA_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_rem,
  output logic              irq_req,
  output logic              irq_reply
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int NREG   = 11;
  localparam int I_CCTL = 0, I_CADR = 1, I_COUT = 2, I_CIN = 3;
  localparam int I_PCTL = 4, I_PADR = 5, I_PREM = 6, I_RSV = 7;
  localparam int I_KCTL = 8, I_KADR = 9, I_KREM = 10;

  logic [DATA_W-1:0] regs [NREG];
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [NREG-1:0]   wsel;

  assign idx = bus_addr[ADDR_W-1:2];
  assign hit = (&bus_be) && (bus_addr[1:0] == 2'b00) &&
               (idx < IDX_W'(NREG)) && (idx != IDX_W'(I_RSV));

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wsel[i] = bus_wr && hit && (idx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wsel[i]) regs[i] <= (i == I_CCTL) ? (bus_wdata & ~DATA_W'(1)) : bus_wdata;
      if (play_wb_addr_en) regs[I_PADR] <= play_wb_addr;
      if (play_wb_rem_en)  regs[I_PREM] <= play_wb_rem;
      if (cap_wb_addr_en)  regs[I_KADR] <= cap_wb_addr;
      if (cap_wb_rem_en)   regs[I_KREM] <= cap_wb_rem;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_reply <= 1'b0;
    end else begin
      irq_req   <= wsel[I_CCTL] && bus_wdata[0] &&  bus_wdata[1];
      irq_reply <= wsel[I_CCTL] && bus_wdata[0] && !bus_wdata[1];
    end
  end

  assign bus_rdata  = (bus_rd && hit) ? regs[idx[3:0]] : '0;

  assign codec_ctrl = regs[I_CCTL];
  assign codec_addr = regs[I_CADR];
  assign codec_dout = regs[I_COUT];
  assign codec_din  = regs[I_CIN];
  assign play_en    = regs[I_PCTL][0];
  assign play_addr  = regs[I_PADR];
  assign play_rem   = regs[I_PREM];
  assign cap_en     = regs[I_KCTL][0];
  assign cap_addr   = regs[I_KADR];
  assign cap_rem    = regs[I_KREM];
endmodule

// File: rtl/codec_regbank_chk.sv
module codec_regbank_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              play_wb_addr_en,
  input logic [DATA_W-1:0] play_wb_addr,
  input logic              cap_wb_rem_en,
  input logic [DATA_W-1:0] cap_wb_rem,
  input logic [DATA_W-1:0] play_addr,
  input logic [DATA_W-1:0] cap_rem,
  input logic              play_en,
  input logic              cap_en,
  input logic              irq_req,
  input logic              irq_reply
);
  logic ok_acc, ctl_wr;
  assign ok_acc = (&bus_be) && (bus_addr[1:0] == 2'b00);
  assign ctl_wr = bus_wr && ok_acc && (bus_addr[ADDR_W-1:2] == '0);

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[0] && bus_wdata[1]) |=> (irq_req && !irq_reply));
  p_reply_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[0] && !bus_wdata[1]) |=> (irq_reply && !irq_req));
  p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && irq_reply));
  p_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && bus_wdata[0]) |=> (!irq_req && !irq_reply));
  p_ctl_bit0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ok_acc && bus_addr[ADDR_W-1:2] == '0) |-> !bus_rdata[0]);
  p_rsv_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(7)) |-> bus_rdata == '0);
  p_play_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ok_acc && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4)) |-> bus_rdata[0] == play_en);
  p_cap_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ok_acc && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(8)) |-> bus_rdata[0] == cap_en);
  p_wb_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    play_wb_addr_en |=> play_addr == $past(play_wb_addr));
  p_wb_rem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_wb_rem_en |=> cap_rem == $past(cap_wb_rem));
endmodule

bind codec_regbank codec_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .play_wb_addr_en(play_wb_addr_en),
  .play_wb_addr(play_wb_addr), .cap_wb_rem_en(cap_wb_rem_en),
  .cap_wb_rem(cap_wb_rem), .play_addr(play_addr), .cap_rem(cap_rem),
  .play_en(play_en), .cap_en(cap_en), .irq_req(irq_req), .irq_reply(irq_reply)
);

// File: tb/codec_regbank_tb_top.sv
module codec_regbank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [5:0] bus_addr = '0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pwa_en = 0, pwr_en = 0, cwa_en = 0, cwr_en = 0;
  logic [31:0] pwa = '0, pwr = '0, cwa = '0, cwr = '0;
  logic [31:0] codec_ctrl, codec_addr, codec_dout, codec_din;
  logic [31:0] play_addr, play_rem, cap_addr, cap_rem;
  logic play_en, cap_en, irq_req, irq_reply;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  codec_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .play_wb_addr_en(pwa_en), .play_wb_addr(pwa),
    .play_wb_rem_en(pwr_en), .play_wb_rem(pwr),
    .cap_wb_addr_en(cwa_en), .cap_wb_addr(cwa),
    .cap_wb_rem_en(cwr_en), .cap_wb_rem(cwr),
    .codec_ctrl(codec_ctrl), .codec_addr(codec_addr),
    .codec_dout(codec_dout), .codec_din(codec_din),
    .play_en(play_en), .play_addr(play_addr), .play_rem(play_rem),
    .cap_en(cap_en), .cap_addr(cap_addr), .cap_rem(cap_rem),
    .irq_req(irq_req), .irq_reply(irq_reply));

  // {index, write data, expected read-back}
  localparam logic [67:0] VEC [12] = '{
    {4'd0,  32'h1234_5677, 32'h1234_5676},
    {4'd1,  32'h0000_0ABC, 32'h0000_0ABC},
    {4'd2,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {4'd3,  32'h0BAD_F00D, 32'h0BAD_F00D},
    {4'd4,  32'h0000_0011, 32'h0000_0011},
    {4'd5,  32'h8000_1000, 32'h8000_1000},
    {4'd6,  32'h0000_0400, 32'h0000_0400},
    {4'd7,  32'hFFFF_FFFF, 32'h0000_0000},
    {4'd8,  32'h0000_0010, 32'h0000_0010},
    {4'd9,  32'h9000_2000, 32'h9000_2000},
    {4'd10, 32'h0000_0800, 32'h0000_0800},
    {4'd13, 32'h5555_5555, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [5:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    bus_rd = 0; bus_be = 4'hF;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 11; i++) begin
      rd(6'(i * 4), 4'hF, v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset irq", {30'd0, irq_req, irq_reply}, 0);
    chk("R1 reset exports", play_addr | cap_rem | codec_ctrl, 0);

    // R2 R4 R9 table walk: write all, then read all
    foreach (VEC[i]) wr({VEC[i][67:64], 2'b00}, VEC[i][63:32], 4'hF);
    foreach (VEC[i]) begin
      rd({VEC[i][67:64], 2'b00}, 4'hF, v);
      chk($sformatf("R2/R4/R9 index %0d", VEC[i][67:64]), v, VEC[i][31:0]);
    end
    chk("R2 codec_dout export", codec_dout, 32'hDEAD_BEEF);
    chk("R2 codec_din export", codec_din, 32'h0BAD_F00D);
    chk("R2 cap_addr export", cap_addr, 32'h9000_2000);
    chk("R4 codec_ctrl export", codec_ctrl, 32'h1234_5676);
    chk("R8 enables 1/0", {30'd0, play_en, cap_en}, 32'd2);
    wr(6'd16, 32'h0, 4'hF);
    wr(6'd32, 32'h1, 4'hF);
    #1 chk("R8 enables 0/1", {30'd0, play_en, cap_en}, 32'd1);

    // R5 request pulse
    wr(6'd0, 32'h3, 4'hF);
    chk("R5 irq_req high", {30'd0, irq_req, irq_reply}, 32'd2);
    @(negedge clk);
    chk("R5 irq_req one cycle", {30'd0, irq_req, irq_reply}, 0);
    // R6 reply pulse
    wr(6'd0, 32'h1, 4'hF);
    chk("R6 irq_reply high", {30'd0, irq_req, irq_reply}, 32'd1);
    @(negedge clk);
    chk("R6 irq_reply one cycle", {30'd0, irq_req, irq_reply}, 0);
    // R7 no request bit
    wr(6'd0, 32'h2, 4'hF);
    chk("R7 no irq", {30'd0, irq_req, irq_reply}, 0);
    rd(6'd0, 4'hF, v);
    chk("R7 ctrl read", v, 32'h2);

    // R3 partial accesses
    wr(6'd20, 32'hCAFE_0000, 4'h3);
    rd(6'd20, 4'hF, v);
    chk("R3 partial write ignored", v, 32'h8000_1000);
    rd(6'd20, 4'h1, v);
    chk("R3 partial read zero", v, 0);
    // R9 misaligned and out-of-range
    wr(6'd21, 32'h1111_1111, 4'hF);
    wr(6'd60, 32'h2222_2222, 4'hF);
    rd(6'd20, 4'hF, v);
    chk("R9 misaligned write ignored", v, 32'h8000_1000);
    rd(6'd21, 4'hF, v);
    chk("R9 misaligned read zero", v, 0);
    rd(6'd60, 4'hF, v);
    chk("R9 index 15 read zero", v, 0);

    // R10 write-back
    @(negedge clk);
    pwa_en = 1; pwa = 32'h8000_1100;
    @(negedge clk);
    pwa_en = 0;
    chk("R10 play addr write-back", play_addr, 32'h8000_1100);
    @(negedge clk);
    pwr_en = 1; pwr = 32'h0000_0300;
    bus_wr = 1; bus_addr = 6'd24; bus_wdata = 32'h0000_0FFF;
    @(negedge clk);
    pwr_en = 0; bus_wr = 0;
    chk("R10 write-back wins", play_rem, 32'h0000_0300);
    @(negedge clk);
    cwa_en = 1; cwa = 32'h9000_2040;
    bus_wr = 1; bus_addr = 6'd40; bus_wdata = 32'h0000_0123;
    @(negedge clk);
    cwa_en = 0; bus_wr = 0;
    chk("R10 cap addr write-back", cap_addr, 32'h9000_2040);
    chk("R10 other bus write lands", cap_rem, 32'h0000_0123);
    @(negedge clk);
    cwr_en = 1; cwr = 32'h0000_0040;
    @(negedge clk);
    cwr_en = 0;
    chk("R10 cap rem write-back", cap_rem, 32'h0000_0040);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 11; i++) begin
      rd(6'(i * 4), 4'hF, v);
      chk("R1 mid-run reset read", v, 0);
    end
    chk("R1 mid-run reset enables", {30'd0, play_en, cap_en}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule